// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block receives asynchronous serial characters on a single data line. Every rising edge of `clk` is one edge of the receive clock, and the line is sampled there. A programmable multiplier sets how many edges make up one bit: one, sixteen, thirty-two or sixty-four.

A falling line starts a start-bit check. The receiver looks at the line again half a bit later, so a short glitch does not start a character. Five to eight data bits are taken least significant bit first, followed by an optional parity bit and one stop bit. The finished character is placed in a small queue of holding slots. Its parity, framing and overrun flags travel with it through the queue.

The host sees the head of the queue and removes it with a one-cycle read strobe. Two one-cycle event outputs mark the start and the end of a line break, for use by an interrupt controller. The receiver is idle after reset until `rx_en` is raised.

Top module: `async_rx_fifo`

## Requirements
- R1: After reset, `rx_avail`, `rx_data`, all three error flags, `brk_start` and `brk_end` are 0.
- R2: `rate_sel` sets the bit period: code 0 is one clock, 1 is 16, 2 is 32 and 3 is 64. Every bit after the start bit is sampled one full period after the previous sample. In the 16, 32 and 64 modes the first sample falls half a period after the falling edge that was seen.
- R3: In the 16, 32 and 64 modes, a low pulse shorter than half a bit period that returns high produces no character and no break event. In the one-clock mode the half-bit check is skipped.
- R4: `char_len` code 0 to 3 selects 5 to 8 data bits. The bits are received least significant first, and `rx_data` holds them right-justified with the unused upper bits at 0.
- R5: When `par_en` is 1, one parity bit follows the data. `par_odd`=1 asks for an odd count of ones over data plus parity, and 0 asks for an even count. A mismatch sets `err_parity` for that character only. When `par_en` is 0, `err_parity` is always 0.
- R6: A low stop bit on a frame that is not a break stores the character with `err_frame`=1. The search for the next start bit then begins half a bit later than it would otherwise.
- R7: Three holding slots form a first-in first-out queue. `rx_avail` is 1 while any slot is filled. `rd_strobe` removes the head, and each character keeps its own flags.
- R8: A character that completes while all slots are full, with no read in that cycle, replaces the newest slot and has `err_overrun`=1. The older slots are unchanged.
- R9: `rd_strobe` while the queue is empty has no effect.
- R10: A frame whose data, parity and stop bits are all 0 stores no character and gives one `brk_start` pulse. One `brk_end` pulse follows once the line is seen high again.
- R11: While `rx_en` is 0 the receiver is idle and ignores the line. Dropping `rx_en` in the middle of a frame discards that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the receive sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rate_sel | input | 2 | Clock multiplier code (0:x1, 1:x16, 2:x32, 3:x64) |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rxd | input | 1 | Serial data line, idle high |
| rd_strobe | input | 1 | Remove the head character |
| rx_avail | output | 1 | Queue holds at least one character |
| rx_data | output | 8 | Head character, 0 when empty |
| err_parity | output | 1 | Parity flag of the head character |
| err_frame | output | 1 | Framing flag of the head character |
| err_overrun | output | 1 | Overrun flag of the head character |
| brk_start | output | 1 | One-cycle pulse when a break is found |
| brk_end | output | 1 | One-cycle pulse when a break ends |

## Verification
A character reaches the queue outputs two edges after the edge that samples its stop bit. The bench therefore holds the line high for one bit period plus three clocks after each stop bit before it reads the head. A read strobe takes effect at the next edge, so the next head is compared at the following falling edge. `brk_start` comes one edge after the break's stop sample, and `brk_end` one edge after the first high sample. The bench counts these pulses at falling edges and compares the totals after windows that are longer than those delays.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int CNT_W = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FWAIT, S_BRK
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       ovr;
  } rx_entry_t;

  // clocks per bit for a multiplier code
  function automatic logic [CNT_W-1:0] bit_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd1;
      2'd1:    return 7'd16;
      2'd2:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  // half a bit, at least one clock
  function automatic logic [CNT_W-1:0] half_period(input logic [1:0] sel);
    if (sel == 2'd0) return 7'd1;
    return bit_period(sel) >> 1;
  endfunction

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // data arrives at the top of the shifter; move it down to bit 0
  function automatic logic [7:0] justify(input logic [7:0] sr, input logic [1:0] len);
    return sr >> (2'd3 - len);
  endfunction

  function automatic logic parity_bad(input logic [7:0] d, input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/arx_deser.sv
module arx_deser
  import arx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] rate_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  output logic       push,
  output rx_entry_t  push_entry,
  output logic       brk_start,
  output logic       brk_end
);
  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sr;
  logic [3:0]       nbit;
  logic             pbit;

  // named internal events
  logic       sample_now;
  logic [7:0] data_j;
  logic       stop_bad;
  logic       is_break;

  assign sample_now = (cnt == '0);
  assign data_j     = justify(sr, char_len);
  assign stop_bad   = (state == S_STOP) && sample_now && !rxd;
  assign is_break   = (data_j == 8'd0) && !pbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sr         <= '0;
      nbit       <= '0;
      pbit       <= 1'b0;
      push       <= 1'b0;
      push_entry <= '0;
      brk_start  <= 1'b0;
      brk_end    <= 1'b0;
    end else begin
      push      <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (!rx_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (!rxd) begin
            sr   <= '0;
            nbit <= '0;
            pbit <= 1'b0;
            if (rate_sel == 2'd0) begin
              state <= S_DATA;
              cnt   <= '0;
            end else begin
              state <= S_START;
              cnt   <= half_period(rate_sel) - 7'd1;
            end
          end
          S_START: if (sample_now) begin
            if (!rxd) begin
              state <= S_DATA;
              cnt   <= bit_period(rate_sel) - 7'd1;
            end else begin
              state <= S_IDLE;
            end
          end else cnt <= cnt - 7'd1;
          S_DATA: if (sample_now) begin
            sr   <= {rxd, sr[7:1]};
            nbit <= nbit + 4'd1;
            cnt  <= bit_period(rate_sel) - 7'd1;
            if (nbit == data_bits(char_len) - 4'd1) state <= par_en ? S_PAR : S_STOP;
          end else cnt <= cnt - 7'd1;
          S_PAR: if (sample_now) begin
            pbit  <= rxd;
            cnt   <= bit_period(rate_sel) - 7'd1;
            state <= S_STOP;
          end else cnt <= cnt - 7'd1;
          S_STOP: if (sample_now) begin
            if (rxd) begin
              push       <= 1'b1;
              push_entry <= '{data: data_j, perr: par_en & parity_bad(data_j, pbit, par_odd),
                              ferr: 1'b0, ovr: 1'b0};
              state      <= S_IDLE;
            end else if (is_break) begin
              brk_start <= 1'b1;
              state     <= S_BRK;
            end else begin
              push       <= 1'b1;
              push_entry <= '{data: data_j, perr: par_en & parity_bad(data_j, pbit, par_odd),
                              ferr: 1'b1, ovr: 1'b0};
              state      <= S_FWAIT;
              cnt        <= half_period(rate_sel) - 7'd1;
            end
          end else cnt <= cnt - 7'd1;
          S_FWAIT: if (sample_now) state <= S_IDLE;
                   else cnt <= cnt - 7'd1;
          S_BRK: if (rxd) begin
            brk_end <= 1'b1;
            state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R10: a frame ends in exactly one way, so its events never overlap
  p_event_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, brk_start, brk_end}));

  // R10: the line stays in break while it is low
  p_brk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == S_BRK && !rxd) |=> (state == S_BRK || !rx_en) && !push);

  // R11: with the receiver off nothing is produced and the state machine rests
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == S_IDLE && !push && !brk_start);

  // R6: right after a framing error the receiver is not yet searching or assembling
  p_fe_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.ferr) |-> state != S_START && state != S_DATA && state != S_IDLE);

  // R6: a bad stop sample that is not a break always enters the hold-off
  p_fe_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && stop_bad && !is_break) |=> state == S_FWAIT);
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo
  import arx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output rx_entry_t head,
  output logic      avail
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t mem   [DEPTH];
  rx_entry_t mem_n [DEPTH];
  logic [CW-1:0] count, cnt_n;
  logic do_pop;
  logic overrun_evt;

  assign do_pop = pop && (count != '0);

  always_comb begin
    mem_n       = mem;
    cnt_n       = count;
    overrun_evt = 1'b0;
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i + 1];
      cnt_n = count - CW'(1);
    end
    if (push) begin
      if (cnt_n < CW'(DEPTH)) begin
        mem_n[cnt_n] = din;
        cnt_n        = cnt_n + CW'(1);
      end else begin
        overrun_evt          = 1'b1;
        mem_n[DEPTH-1]       = din;
        mem_n[DEPTH-1].ovr   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count <= cnt_n;
      mem   <= mem_n;
    end
  end

  assign head  = mem[0];
  assign avail = (count != '0);

  // R7: occupancy never exceeds the slot count
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: a read of an empty queue leaves it empty
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push) |=> count == '0);

  // R8: a push into a full queue keeps it full and leaves the head alone
  p_ovr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == CW'(DEPTH)) |=> count == CW'(DEPTH) && $stable(head));

  // R8: the overrun flag only appears on the newest slot after an overrun event
  p_ovr_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> mem[DEPTH-1].ovr);
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
  import arx_pkg::*;
#(
  parameter int HOLD_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] rate_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  input  logic       rd_strobe,
  output logic       rx_avail,
  output logic [7:0] rx_data,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       brk_start,
  output logic       brk_end
);
  logic      push;
  rx_entry_t push_entry;
  rx_entry_t head;
  logic      avail;

  arx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rate_sel(rate_sel),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
    .push(push), .push_entry(push_entry),
    .brk_start(brk_start), .brk_end(brk_end)
  );

  arx_fifo #(.DEPTH(HOLD_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_entry),
    .pop(rd_strobe), .head(head), .avail(avail)
  );

  assign rx_avail    = avail;
  assign rx_data     = avail ? head.data : 8'd0;
  assign err_parity  = avail & head.perr;
  assign err_frame   = avail & head.ferr;
  assign err_overrun = avail & head.ovr;

  // R4: unused upper bits of a stored character are always zero
  p_len_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_entry.data >> data_bits(char_len)) == 8'd0);
endmodule

// File: tb/async_rx_fifo_tb_top.sv
module async_rx_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] rate_sel = 2'd1;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_strobe = 1'b0;
  logic       rx_avail;
  logic [7:0] rx_data;
  logic       err_parity, err_frame, err_overrun, brk_start, brk_end;

  int n_checks = 0;
  int n_fail = 0;
  int n_bstart = 0;
  int n_bend = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  async_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rate_sel(rate_sel),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
    .rd_strobe(rd_strobe), .rx_avail(rx_avail), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .brk_start(brk_start), .brk_end(brk_end)
  );

  always @(negedge clk) begin
    if (brk_start) n_bstart++;
    if (brk_end) n_bend++;
  end

  function automatic int clocks_per_bit(input logic [1:0] code);
    int t;
    t = (code == 2'd0) ? 1 : (8 << code);
    return t;
  endfunction

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] ln);
    return d & ((8'd1 << (5 + ln)) - 8'd1);
  endfunction

  function automatic logic good_parity(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2 == 1) ? ~odd : odd;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int cyc);
    rxd = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] rs, input logic [1:0] ln, input logic pe,
                      input logic po, input logic [7:0] d, input logic flip_par,
                      input logic stopv);
    int n = clocks_per_bit(rs);
    logic [7:0] dm = mask_len(d, ln);
    rate_sel = rs; char_len = ln; par_en = pe; par_odd = po;
    hold(1'b0, n);
    for (int i = 0; i < 5 + ln; i++) hold(dm[i], n);
    if (pe) hold(good_parity(dm, po) ^ flip_par, n);
    hold(stopv, n);
    hold(1'b1, n + 3);
  endtask

  task automatic pop_one();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_head(input string tag, input logic [7:0] d, input logic pe_f,
                             input logic fe_f, input logic ov_f);
    chk({tag, " avail"}, rx_avail, 1);
    chk({tag, " data"}, rx_data, d);
    chk({tag, " perr"}, err_parity, pe_f);
    chk({tag, " ferr"}, err_frame, fe_f);
    chk({tag, " ovr"}, err_overrun, ov_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 avail", rx_avail, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {err_parity, err_frame, err_overrun}, 0);
    chk("R1 break", {brk_start, brk_end}, 0);

    // R11 disabled receiver ignores a full frame
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1);
    chk("R11 off no char", rx_avail, 0);

    rx_en = 1'b1;
    @(negedge clk);
    // R2 R4 x16, eight bits
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1);
    expect_head("R2 R4 x16", 8'hA5, 0, 0, 0);
    pop_one();
    chk("R7 empty after read", rx_avail, 0);

    // R2 R5 x1, five bits, odd parity
    send(2'd0, 2'd0, 1'b1, 1'b1, 8'h13, 1'b0, 1'b1);
    expect_head("R2 R5 x1 odd", 8'h13, 0, 0, 0);
    pop_one();

    // R4 x64, six bits, upper bits dropped
    send(2'd3, 2'd1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1);
    expect_head("R4 x64 six", 8'h3F, 0, 0, 0);
    pop_one();

    // R3 spike shorter than half a bit
    rate_sel = 2'd1;
    hold(1'b0, 3);
    hold(1'b1, 80);
    chk("R3 spike no char", rx_avail, 0);
    chk("R3 spike no break", n_bstart, 0);

    // R5 bad even parity at x32, seven bits
    send(2'd2, 2'd2, 1'b1, 1'b0, 8'h41, 1'b1, 1'b1);
    expect_head("R5 bad parity", 8'h41, 1, 0, 0);
    pop_one();

    // R6 framing error, then a clean character; R7 flags stay per character
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0);
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1);
    expect_head("R6 frame err", 8'h3C, 0, 1, 0);
    pop_one();
    expect_head("R7 next clean", 8'h5A, 0, 0, 0);
    pop_one();

    // R6 bad stop bit run straight into the next start bit
    rate_sel = 2'd1; char_len = 2'd3; par_en = 1'b0;
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(i[0], 16);
    hold(1'b0, 16);
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1);
    expect_head("R6 back to back ferr", 8'hAA, 0, 1, 0);
    pop_one();
    expect_head("R6 resync char", 8'hC3, 0, 0, 0);
    pop_one();

    // R8 overrun on the fourth character
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b1);
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h33, 1'b0, 1'b1);
    send(2'd1, 2'd3, 1'b0, 1'b0, 8'h44, 1'b0, 1'b1);
    expect_head("R8 first", 8'h11, 0, 0, 0);
    pop_one();
    expect_head("R8 second", 8'h22, 0, 0, 0);
    pop_one();
    expect_head("R8 newest overwrote", 8'h44, 0, 0, 1);
    pop_one();
    chk("R8 drained", rx_avail, 0);

    // R9 read of empty queue
    pop_one();
    chk("R9 still empty", rx_avail, 0);
    send(2'd1, 2'd2, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b1);
    expect_head("R9 after empty read", 8'h6E, 0, 0, 0);
    pop_one();

    // R10 break with parity enabled
    rate_sel = 2'd1; char_len = 2'd3; par_en = 1'b1;
    hold(1'b0, 16 * 12);
    chk("R10 break start once", n_bstart, 1);
    chk("R10 no end while low", n_bend, 0);
    chk("R10 no char", rx_avail, 0);
    hold(1'b1, 4);
    chk("R10 break end once", n_bend, 1);
    hold(1'b1, 40);
    chk("R10 no extra events", n_bstart + n_bend, 2);

    // R11 abort mid-frame
    rate_sel = 2'd1; char_len = 2'd3; par_en = 1'b0;
    hold(1'b0, 16);
    hold(1'b0, 16);
    hold(1'b1, 8);
    rx_en = 1'b0;
    hold(1'b1, 64);
    rx_en = 1'b1;
    hold(1'b1, 64);
    chk("R11 aborted frame", rx_avail, 0);

    // random traffic over R2 R4 R5
    for (int k = 0; k < 40; k++) begin
      logic [1:0] rs = 2'($urandom_range(0, 3));
      logic [1:0] ln = 2'($urandom_range(0, 3));
      logic pe = 1'($urandom_range(0, 1));
      logic po = 1'($urandom_range(0, 1));
      logic fl = ($urandom_range(0, 3) == 0);
      logic [7:0] d = 8'($urandom);
      send(rs, ln, pe, po, d, fl, 1'b1);
      expect_head("R2 R4 R5 random", mask_len(d, ln), pe & fl, 0, 0);
      pop_one();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule